// File: doc/BRIEF.md
# Masked BSSID Receive Address Filter

This block decides, one frame at a time, whether the network identifier carried in a received frame belongs to the station, so that the frame may be acknowledged. It does not demand an exact match. It compares the 48-bit frame identifier with the local 48-bit station address only on the bit positions that a programmable 48-bit mask selects. When a station hosts several networks, the mask keeps only the bits that the station address and every hosted identifier share. Frames for all hosted networks then pass. A foreign identifier that happens to agree on the kept bits also passes, and this is the intended behaviour.

The station address and the mask are loaded through a small write port. Each value is split into a low 32-bit word and an upper 16-bit word. A helper accumulator can also build the mask directly. It is cleared to all ones, and then each hosted identifier is applied to it on its own strobe. The verdict is registered and appears one cycle after the frame strobe.

Top module: `bssid_rx_filter`

## Requirements
- R1: The verdict appears one cycle after the frame strobe. `accept_valid` is high in exactly the cycle after `frame_valid` was high. `accept` is 1 in that cycle when (`frame_bssid` AND mask) equals (mask AND station address), and 0 otherwise. `accept` is 0 whenever `accept_valid` is 0.
- R2: After reset, the station address is all zeros, the mask is all ones, and `accept` and `accept_valid` are 0.
- R3: A write with `wr_addr` = 0 loads station address bits 31:0 from `wr_data`. Byte 0 of the address sits in bits 7:0. A write with `wr_addr` = 1 loads address bits 47:32 from `wr_data[15:0]`, ignores `wr_data[31:16]`, and leaves address bits 31:0 unchanged.
- R4: A write with `wr_addr` = 2 loads mask bits 31:0. A write with `wr_addr` = 3 loads mask bits 47:32 from `wr_data[15:0]`, ignores `wr_data[31:16]`, and leaves mask bits 31:0 unchanged.
- R5: `acc_clear` sets every mask bit to 1 at the next edge.
- R6: `acc_add` replaces the mask with mask AND NOT(station address XOR `acc_bssid`). One identifier is applied per cycle, and a mask bit never goes from 0 to 1 through this path.
- R7: When more than one mask update happens in the same cycle, `acc_clear` wins over `acc_add`, and `acc_add` wins over a register write to the mask.
- R8: With an all-ones mask, only a frame identifier equal to the station address is accepted.
- R9: A frame identifier that is not hosted but agrees with the station address on every masked bit is accepted.
- R10: A frame is judged against the address and mask held before the edge that captures it. A write or accumulator update in that same cycle takes effect only for later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 address low, 1 address high, 2 mask low, 3 mask high |
| wr_data | input | 32 | Register write data |
| acc_clear | input | 1 | Set the mask to all ones |
| acc_add | input | 1 | Fold `acc_bssid` into the mask |
| acc_bssid | input | 48 | Hosted identifier applied by `acc_add` |
| frame_valid | input | 1 | Frame identifier present this cycle |
| frame_bssid | input | 48 | Received frame identifier |
| accept | output | 1 | Frame accepted (registered) |
| accept_valid | output | 1 | Verdict present this cycle (registered) |

## Verification
The assertions take for granted that the inputs hold known values outside reset. They also assume that every strobe lasts exactly one cycle, so that the one-cycle verdict and the mask monotonicity can be judged edge by edge. The stimulus drives every input on the falling clock edge and keeps each input constant for a whole cycle. Clear, add and register writes are mixed freely, including all three in the same cycle. The identifiers that are folded into the mask differ from the station address in only a few random bits, so the mask does not collapse to zero and the probe frames keep telling accept apart from reject.

// File: rtl/bssid_filt_pkg.sv
// Shared register selects for the masked identifier filter.
package bssid_filt_pkg;
    typedef enum logic [1:0] {
        SEL_ADDR_LO = 2'd0,
        SEL_ADDR_HI = 2'd1,
        SEL_MASK_LO = 2'd2,
        SEL_MASK_HI = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/bssid_word_reg.sv
// Two-word address register.
// Holds an ADDR_W-bit value that is written as a WORD_W-bit low word and an
// upper word. The upper word takes the low bits of the write data.
// An override port takes precedence over both word writes.
// Assumes ADDR_W > WORD_W and that ADDR_W - WORD_W <= WORD_W.
module bssid_word_reg #(
    parameter int                ADDR_W  = 48,
    parameter int                WORD_W  = 32,
    parameter logic [ADDR_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              ovr_en,
    input  logic [ADDR_W-1:0] ovr_val,
    output logic [ADDR_W-1:0] q
);
    localparam int HI_W = ADDR_W - WORD_W;

    // Purpose: store the value, override first, then the word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (ovr_en) begin
            q <= ovr_val;
        end else begin
            if (lo_we) q[WORD_W-1:0]      <= wdata;
            if (hi_we) q[ADDR_W-1:WORD_W] <= wdata[HI_W-1:0];
        end
    end
endmodule

// File: rtl/bssid_mask_acc.sv
// Mask accumulator next-state logic.
// Clear forces every bit to one. Add keeps only the bits on which the station
// address and the supplied identifier agree. Pure combinational logic: the
// mask storage lives in a bssid_word_reg.
// Assumes the caller gives upd_en priority over register writes.
module bssid_mask_acc #(
    parameter int ADDR_W = 48
) (
    input  logic              clear,
    input  logic              add,
    input  logic [ADDR_W-1:0] bssid,
    input  logic [ADDR_W-1:0] mac,
    input  logic [ADDR_W-1:0] mask_q,
    output logic              upd_en,
    output logic [ADDR_W-1:0] upd_val
);
    assign upd_en = clear | add;

    // Purpose: per-bit next mask, clear over add.
    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        assign upd_val[b] = clear ? 1'b1 : (mask_q[b] & (mac[b] ~^ bssid[b]));
    end
endmodule

// File: rtl/bssid_match.sv
// Masked compare with a registered verdict.
// A frame is accepted when it differs from the station address only on
// unmasked bits. The verdict follows frame_valid by one cycle.
// Assumes mac and mask are stable register outputs.
module bssid_match #(
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_valid,
    input  logic [ADDR_W-1:0] frame_bssid,
    input  logic [ADDR_W-1:0] mac,
    input  logic [ADDR_W-1:0] mask,
    output logic              accept,
    output logic              accept_valid
);
    logic hit;

    // Purpose: no masked bit may differ from the station address.
    always_comb hit = ~|((frame_bssid ^ mac) & mask);

    // Purpose: register the verdict one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept       <= 1'b0;
            accept_valid <= 1'b0;
        end else begin
            accept       <= frame_valid & hit;
            accept_valid <= frame_valid;
        end
    end
endmodule

// File: rtl/bssid_rx_filter.sv
// Masked receive identifier filter, top level.
// Decodes the register write port into the station address and mask words,
// drives the mask accumulator, and judges each frame identifier.
// Assumes single-cycle strobes on all control inputs.
module bssid_rx_filter
    import bssid_filt_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              acc_clear,
    input  logic              acc_add,
    input  logic [ADDR_W-1:0] acc_bssid,
    input  logic              frame_valid,
    input  logic [ADDR_W-1:0] frame_bssid,
    output logic              accept,
    output logic              accept_valid
);
    localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] mac_q;
    logic [ADDR_W-1:0] mask_q;
    logic [ADDR_W-1:0] acc_val;
    logic              acc_en;
    logic              we_addr_lo, we_addr_hi, we_mask_lo, we_mask_hi;

    // Purpose: decode the write select into word enables.
    always_comb begin
        we_addr_lo = wr_en && (wr_addr == SEL_ADDR_LO);
        we_addr_hi = wr_en && (wr_addr == SEL_ADDR_HI);
        we_mask_lo = wr_en && (wr_addr == SEL_MASK_LO);
        we_mask_hi = wr_en && (wr_addr == SEL_MASK_HI);
    end

    bssid_word_reg #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .RST_VAL('0)) u_mac (
        .clk(clk), .rst_n(rst_n),
        .lo_we(we_addr_lo), .hi_we(we_addr_hi), .wdata(wr_data),
        .ovr_en(1'b0), .ovr_val('0), .q(mac_q)
    );

    bssid_mask_acc #(.ADDR_W(ADDR_W)) u_acc (
        .clear(acc_clear), .add(acc_add), .bssid(acc_bssid),
        .mac(mac_q), .mask_q(mask_q), .upd_en(acc_en), .upd_val(acc_val)
    );

    bssid_word_reg #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .RST_VAL(ALL_ONES)) u_mask (
        .clk(clk), .rst_n(rst_n),
        .lo_we(we_mask_lo), .hi_we(we_mask_hi), .wdata(wr_data),
        .ovr_en(acc_en), .ovr_val(acc_val), .q(mask_q)
    );

    bssid_match #(.ADDR_W(ADDR_W)) u_match (
        .clk(clk), .rst_n(rst_n),
        .frame_valid(frame_valid), .frame_bssid(frame_bssid),
        .mac(mac_q), .mask(mask_q),
        .accept(accept), .accept_valid(accept_valid)
    );
endmodule

// File: rtl/bssid_rx_filter_chk.sv
// Property checker for bssid_rx_filter, attached by bind.
// Observes ports plus the address and mask registers.
// Assumes inputs hold known values whenever reset is released.
module bssid_rx_filter_chk #(
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic              acc_clear,
    input logic              acc_add,
    input logic              frame_valid,
    input logic [ADDR_W-1:0] frame_bssid,
    input logic              accept,
    input logic              accept_valid,
    input logic [ADDR_W-1:0] mac_q,
    input logic [ADDR_W-1:0] mask_q
);
    assert_verdict_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> accept_valid);
    assert_no_stray_verdict_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> !accept_valid);
    assert_accept_qualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> accept_valid);
    assert_hi_keeps_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1) |=> $stable(mac_q[31:0]));
    assert_clear_all_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clear |=> (&mask_q));
    assert_add_only_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_add && !acc_clear) |=> ((mask_q & ~$past(mask_q)) == '0));
    assert_exact_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && (&mask_q) && frame_bssid != mac_q) |=> !accept);
    assert_own_address_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && frame_bssid == mac_q) |=> accept);
endmodule

bind bssid_rx_filter bssid_rx_filter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .acc_clear(acc_clear), .acc_add(acc_add),
    .frame_valid(frame_valid), .frame_bssid(frame_bssid),
    .accept(accept), .accept_valid(accept_valid),
    .mac_q(mac_q), .mask_q(mask_q)
);

// File: tb/sim_bssid_rx_filter.sv
module sim_bssid_rx_filter;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          acc_clear = 1'b0;
    logic          acc_add = 1'b0;
    logic [AW-1:0] acc_bssid = '0;
    logic          frame_valid = 1'b0;
    logic [AW-1:0] frame_bssid = '0;
    logic          accept, accept_valid;

    int total = 0;
    int bad = 0;
    logic [AW-1:0] m_mac;
    logic [AW-1:0] m_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    bssid_rx_filter u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .acc_clear(acc_clear), .acc_add(acc_add),
        .acc_bssid(acc_bssid), .frame_valid(frame_valid),
        .frame_bssid(frame_bssid), .accept(accept), .accept_valid(accept_valid)
    );

    function automatic logic exp_accept(logic [AW-1:0] f, logic [AW-1:0] mac,
                                        logic [AW-1:0] mask);
        return ((f & mask) == (mac & mask));
    endfunction

    function automatic logic [AW-1:0] rand48();
        logic [31:0] a = $urandom;
        logic [31:0] b = $urandom;
        return {a[15:0], b};
    endfunction

    task automatic chk(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle of stimulus; checks the verdict, then advances the model.
    task automatic drive(string req, logic clr, logic add, logic [AW-1:0] ab,
                         logic we, logic [1:0] wa, logic [31:0] wd,
                         logic fv, logic [AW-1:0] fb);
        logic e;
        e = exp_accept(fb, m_mac, m_mask);
        @(negedge clk);
        acc_clear = clr; acc_add = add; acc_bssid = ab;
        wr_en = we; wr_addr = wa; wr_data = wd;
        frame_valid = fv; frame_bssid = fb;
        @(negedge clk);
        acc_clear = 1'b0; acc_add = 1'b0; wr_en = 1'b0; frame_valid = 1'b0;
        chk(req, accept_valid, fv);
        chk(req, accept, fv & e);
        if (clr)                     m_mask = '1;
        else if (add)                m_mask = m_mask & ~(m_mac ^ ab);
        else if (we && wa == 2'd2)   m_mask[31:0]  = wd;
        else if (we && wa == 2'd3)   m_mask[47:32] = wd[15:0];
        if (we && wa == 2'd0)        m_mac[31:0]  = wd;
        else if (we && wa == 2'd1)   m_mac[47:32] = wd[15:0];
    endtask

    task automatic frame(string req, logic [AW-1:0] fb);
        drive(req, 1'b0, 1'b0, '0, 1'b0, 2'd0, '0, 1'b1, fb);
    endtask

    task automatic wr(string req, logic [1:0] wa, logic [31:0] wd);
        drive(req, 1'b0, 1'b0, '0, 1'b1, wa, wd, 1'b0, '0);
    endtask

    // Single-bit probes expose every mask bit at the verdict output.
    task automatic probe(string req);
        frame(req, m_mac);
        for (int k = 0; k < AW; k++) frame(req, m_mac ^ (48'd1 << k));
    endtask

    function automatic logic [AW-1:0] near_mac();
        logic [AW-1:0] v = m_mac;
        for (int i = 0; i < 2; i++) v[$urandom_range(AW-1, 0)] ^= 1'b1;
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] base;
        void'($urandom(32'd4242));
        m_mac = '0; m_mask = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset accept", accept, 1'b0);
        chk("R2 reset accept_valid", accept_valid, 1'b0);
        probe("R2 reset mask all ones, address zero");

        // R3: address words, junk in upper half of the high word
        wr("R3", 2'd0, 32'hA1B2_C3D4);
        wr("R3", 2'd1, 32'hFFFF_5E6F);
        probe("R3 address words / R8 exact");
        frame("R8 one bit off", m_mac ^ 48'h8000_0000_0000);

        // R6 R9: scaled 4-bit example, upper bits equal to the address
        base = {m_mac[47:4], 4'b0000};
        wr("R3", 2'd0, {base[31:4], 4'b0001});
        drive("R5", 1'b1, 1'b0, '0, 1'b0, 2'd0, '0, 1'b0, '0);
        drive("R6", 1'b0, 1'b1, base | 48'h4, 1'b0, 2'd0, '0, 1'b0, '0);
        drive("R6", 1'b0, 1'b1, base | 48'h9, 1'b0, 2'd0, '0, 1'b0, '0);
        chk("R6 model mask", m_mask[3:0] == 4'b0010, 1'b1);
        frame("R6 foreign 0110 rejected", base | 48'h6);
        chk("R6 reject 0110", accept, 1'b0);
        frame("R1 own 0001", base | 48'h1);
        frame("R6 hosted 0100", base | 48'h4);
        frame("R6 hosted 1001", base | 48'h9);
        frame("R9 foreign 1101 accepted", base | 48'hD);
        chk("R9 accept 1101", accept, 1'b1);
        probe("R6 probe");

        // R4: direct mask words
        wr("R4", 2'd2, 32'h0F0F_00FF);
        wr("R4", 2'd3, 32'h1234_F00F);
        probe("R4 mask words");

        // R5 clear
        drive("R5", 1'b1, 1'b0, '0, 1'b0, 2'd0, '0, 1'b0, '0);
        probe("R5 cleared");

        // R7 priorities
        drive("R6", 1'b0, 1'b1, near_mac(), 1'b0, 2'd0, '0, 1'b0, '0);
        drive("R7 clear wins", 1'b1, 1'b1, near_mac(), 1'b1, 2'd2, 32'h0, 1'b0, '0);
        probe("R7 clear over add and write");
        drive("R7 add wins", 1'b0, 1'b1, near_mac(), 1'b1, 2'd3, 32'h0, 1'b0, '0);
        probe("R7 add over write");

        // R10: update in the same cycle as a frame
        drive("R10 write with frame", 1'b0, 1'b0, '0, 1'b1, 2'd0, 32'h0,
              1'b1, m_mac);
        frame("R10 new address", m_mac);
        drive("R10 clear with frame", 1'b1, 1'b0, '0, 1'b0, 2'd0, '0,
              1'b1, m_mac ^ 48'h1);

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int op = $urandom_range(9, 0);
            logic [AW-1:0] fb = ($urandom_range(1, 0) == 1) ? near_mac() : rand48();
            logic [31:0] wd = $urandom;
            case (op)
                0: drive("R5 rnd", 1'b1, 1'b0, '0, 1'b0, 2'd0, '0,
                         $urandom_range(1, 0) == 1, fb);
                1, 2: drive("R6 rnd", 1'b0, 1'b1, near_mac(), 1'b0, 2'd0, '0,
                            $urandom_range(1, 0) == 1, fb);
                3: drive("R3 rnd", 1'b0, 1'b0, '0, 1'b1,
                         2'($urandom_range(1, 0)), wd, 1'b1, fb);
                4: drive("R4 rnd", 1'b0, 1'b0, '0, 1'b1,
                         2'($urandom_range(3, 2)), wd, 1'b1, fb);
                5: drive("R7 rnd", $urandom_range(1, 0) == 1, 1'b1, near_mac(),
                         1'b1, 2'($urandom_range(3, 2)), wd, 1'b1, fb);
                default: frame("R1 rnd", fb);
            endcase
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule